// File: doc/BRIEF.md
# Eight-Line Priority Interrupt Controller

This block collects up to eight edge-triggered interrupt requests and presents one interrupt line to a processor. Software configures it through a byte-wide register port with two addresses. A start word on the command address opens a configuration sequence. The next three writes to the data address then set, in turn, the vector base, the cascade identity byte and the mode word. After the mode word the block is ready, and any further data-address writes load the mask register.

A rising edge on a request line marks that line pending. The lowest-numbered pending line that is not masked wins. It drives the interrupt output when no line of equal or higher priority is in service. A single-cycle acknowledge strobe returns the vector and moves the winning line from pending into service. A line leaves service only when software names it in a specific end-of-interrupt command.

Top module: `pic8_core`

## Requirements
- R1: After reset, `init_done` and `int_req` are low, the data-address read returns 0xFF (all lines masked) and `cascade_id` is 0x00.
- R2: A command write with bit 4 set is a start word, for example 0x11. It clears the mask register and every in-service bit and drops `init_done`. Pending bits are kept.
- R3: After a start word, the first data write sets the vector base (bits 7:3 kept), the second sets `cascade_id`, and the third (mode word) raises `init_done`. `int_req` stays low until `init_done` is high.
- R4: Once `init_done` is high, a data write loads the mask register (bit n set disables line n), and a data-address read returns the mask. A command-address read returns 0x00.
- R5: A rising edge on `irq_in[n]` sets pending bit n, which stays set until that line is acknowledged. A level held high does not request again.
- R6: A pending line whose mask bit is set does not raise `int_req`. Clearing the mask bit later lets the retained request through.
- R7: Priority is fixed: among unmasked pending lines, the lowest line number wins.
- R8: An acknowledge while `int_req` is high returns `int_vector` = {base[7:3], line}. At the same clock edge the line's pending bit is cleared and its in-service bit is set.
- R9: `int_req` is asserted only when the winning line has a smaller number than every line in service.
- R10: A command write of 0x60 OR n (bits 7:5 = 011, bit 4 clear) clears only in-service bit n. A request that was blocked by that line can then raise `int_req`.
- R11: An acknowledge while `int_req` is low returns {base[7:3], 3'b111} and changes no pending or in-service bit.
- R12: A command write that is neither a start word nor an end-of-interrupt code has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_wr | input | 1 | Register write strobe |
| bus_sel | input | 1 | Address select: 0 command, 1 data |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data (mask at data address) |
| irq_in | input | 8 | Edge-triggered request lines |
| int_req | output | 1 | Interrupt toward the processor |
| int_ack | input | 1 | Single-cycle acknowledge strobe |
| int_vector | output | 8 | Vector valid while int_ack is high |
| cascade_id | output | 8 | Second configuration byte |
| init_done | output | 1 | Configuration sequence complete |

## Verification
The arbitration is driven with several input patterns, and each one separates one kind of fault:
- A masked single request followed by unmasking exposes a mask that is ignored, or a pending bit that is lost.
- A lower-priority request that arrives while a higher line is in service, followed by a higher one, tells real nesting apart from blind first-come service.
- Two lines rising in the same cycle expose a reversed priority order.
- Lines held high across acknowledges show whether a level is wrongly taken as a new edge.

Acknowledges with nothing asserted, unknown command bytes, and a second configuration run in the middle of service cover the boundaries.

// File: rtl/pic8_pkg.sv
package pic8_pkg;
    localparam int unsigned START_BIT = 4;
    localparam logic [2:0]  EOI_OP    = 3'b011;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_BASE,
        ST_CAS,
        ST_MODE,
        ST_READY
    } cfg_step_e;
endpackage

// File: rtl/pic8_cfg.sv
module pic8_cfg
    import pic8_pkg::*;
#(
    parameter int unsigned DW = 8,
    parameter int unsigned N  = 8,
    localparam int unsigned W = $clog2(N)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_i,
    input  logic             sel_i,
    input  logic [DW-1:0]    wdata_i,
    output logic             ready_o,
    output logic [N-1:0]     mask_o,
    output logic [DW-1:W]    base_hi_o,
    output logic [DW-1:0]    cas_o,
    output logic             start_o,
    output logic             eoi_o,
    output logic [W-1:0]     eoi_line_o
);
    typedef struct packed {
        cfg_step_e     step;
        logic [N-1:0]  mask;
        logic [DW-1:W] base_hi;
        logic [DW-1:0] cas;
    } cfg_t;

    cfg_t cfg_d, cfg_q;
    logic cmd_wr, dat_wr;

    always_comb begin
        cmd_wr     = wr_i && !sel_i;
        dat_wr     = wr_i && sel_i;
        start_o    = cmd_wr && wdata_i[START_BIT];
        eoi_o      = cmd_wr && !wdata_i[START_BIT] &&
                     (wdata_i[DW-1:DW-3] == EOI_OP) && (cfg_q.step == ST_READY);
        eoi_line_o = wdata_i[W-1:0];

        cfg_d = cfg_q;
        if (start_o) begin
            cfg_d.step = ST_BASE;
            cfg_d.mask = '0;
        end else if (dat_wr) begin
            unique case (cfg_q.step)
                ST_BASE:  begin
                    cfg_d.base_hi = wdata_i[DW-1:W];
                    cfg_d.step    = ST_CAS;
                end
                ST_CAS:   begin
                    cfg_d.cas  = wdata_i;
                    cfg_d.step = ST_MODE;
                end
                ST_MODE:  cfg_d.step = ST_READY;
                ST_READY: cfg_d.mask = wdata_i[N-1:0];
                default:  cfg_d.step = cfg_q.step;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cfg_q.step    <= ST_IDLE;
            cfg_q.mask    <= '1;
            cfg_q.base_hi <= '0;
            cfg_q.cas     <= '0;
        end else begin
            cfg_q <= cfg_d;
        end
    end

    assign ready_o   = (cfg_q.step == ST_READY);
    assign mask_o    = cfg_q.mask;
    assign base_hi_o = cfg_q.base_hi;
    assign cas_o     = cfg_q.cas;

    AST_START_CLEARS_MASK: assert property (@(posedge clk) disable iff (!rst_n)
        start_o |=> (mask_o == '0) && !ready_o); // R2
    AST_MASK_LOADS: assert property (@(posedge clk) disable iff (!rst_n)
        (dat_wr && ready_o) |=> (mask_o == $past(wdata_i[N-1:0]))); // R4
    AST_MODE_FINISHES: assert property (@(posedge clk) disable iff (!rst_n)
        (dat_wr && cfg_q.step == ST_MODE) |=> ready_o); // R3
endmodule

// File: rtl/pic8_req.sv
module pic8_req #(
    parameter int unsigned N = 8,
    localparam int unsigned W = $clog2(N)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [N-1:0]  irq_i,
    input  logic          clr_isr_i,
    input  logic          take_i,
    input  logic [W-1:0]  take_line_i,
    input  logic          eoi_i,
    input  logic [W-1:0]  eoi_line_i,
    output logic [N-1:0]  pend_o,
    output logic [N-1:0]  isr_o
);
    typedef struct packed {
        logic [N-1:0] prev;
        logic [N-1:0] pend;
        logic [N-1:0] isr;
    } req_t;

    req_t req_d, req_q;
    logic [N-1:0] rise, take_vec, eoi_vec;

    for (genvar g = 0; g < N; g++) begin : g_line
        assign rise[g]     = irq_i[g] && !req_q.prev[g];
        assign take_vec[g] = take_i && (take_line_i == W'(g));
        assign eoi_vec[g]  = eoi_i && (eoi_line_i == W'(g));
    end

    always_comb begin
        req_d      = req_q;
        req_d.prev = irq_i;
        req_d.pend = (req_q.pend & ~take_vec) | rise;
        if (clr_isr_i) req_d.isr = '0;
        else           req_d.isr = (req_q.isr & ~eoi_vec) | take_vec;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            req_q <= '0;
        end else begin
            req_q <= req_d;
        end
    end

    assign pend_o = req_q.pend;
    assign isr_o  = req_q.isr;

    AST_PEND_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        !take_i |=> ((pend_o & $past(pend_o)) == $past(pend_o))); // R5
    AST_TAKE_SETS_ISR: assert property (@(posedge clk) disable iff (!rst_n)
        (take_i && !clr_isr_i) |=> (isr_o[$past(take_line_i)] && !pend_o[$past(take_line_i)]) ||
                                   $past(irq_i[take_line_i])); // R8
    AST_EOI_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (eoi_i && !(take_i && take_line_i == eoi_line_i)) |=> !isr_o[$past(eoi_line_i)]); // R10
endmodule

// File: rtl/pic8_prio.sv
module pic8_prio #(
    parameter int unsigned N = 8,
    localparam int unsigned W = $clog2(N)
) (
    input  logic [N-1:0] req_i,
    input  logic [N-1:0] isr_i,
    output logic [W-1:0] win_o,
    output logic         fire_o
);
    logic [W-1:0] isr_top;

    always_comb begin
        win_o   = '0;
        isr_top = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (req_i[i]) win_o   = W'(i);
            if (isr_i[i]) isr_top = W'(i);
        end
        fire_o = (|req_i) && (!(|isr_i) || (win_o < isr_top));
    end
endmodule

// File: rtl/pic8_core.sv
module pic8_core
    import pic8_pkg::*;
#(
    parameter int unsigned DW = 8,
    parameter int unsigned N  = 8,
    localparam int unsigned W = $clog2(N)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          bus_wr,
    input  logic          bus_sel,
    input  logic [DW-1:0] bus_wdata,
    output logic [DW-1:0] bus_rdata,
    input  logic [N-1:0]  irq_in,
    output logic          int_req,
    input  logic          int_ack,
    output logic [DW-1:0] int_vector,
    output logic [DW-1:0] cascade_id,
    output logic          init_done
);
    logic          ready, start, eoi, fire, take;
    logic [N-1:0]  mask, pend, isr;
    logic [DW-1:W] base_hi;
    logic [W-1:0]  eoi_line, win;

    pic8_cfg #(.DW(DW), .N(N)) u_cfg (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_i       (bus_wr),
        .sel_i      (bus_sel),
        .wdata_i    (bus_wdata),
        .ready_o    (ready),
        .mask_o     (mask),
        .base_hi_o  (base_hi),
        .cas_o      (cascade_id),
        .start_o    (start),
        .eoi_o      (eoi),
        .eoi_line_o (eoi_line)
    );

    pic8_req #(.N(N)) u_req (
        .clk         (clk),
        .rst_n       (rst_n),
        .irq_i       (irq_in),
        .clr_isr_i   (start),
        .take_i      (take),
        .take_line_i (win),
        .eoi_i       (eoi),
        .eoi_line_i  (eoi_line),
        .pend_o      (pend),
        .isr_o       (isr)
    );

    pic8_prio #(.N(N)) u_prio (
        .req_i  (pend & ~mask),
        .isr_i  (isr),
        .win_o  (win),
        .fire_o (fire)
    );

    assign int_req    = ready && fire;
    assign take       = int_ack && int_req;
    assign int_vector = {base_hi, (take ? win : {W{1'b1}})};
    assign bus_rdata  = bus_sel ? DW'(mask) : '0;
    assign init_done  = ready;

    AST_QUIET_UNTIL_READY: assert property (@(posedge clk) disable iff (!rst_n)
        !init_done |-> !int_req); // R3
    AST_NEEDS_UNMASKED: assert property (@(posedge clk) disable iff (!rst_n)
        int_req |-> |(pend & ~mask)); // R6
    AST_SPURIOUS_NO_CHANGE: assert property (@(posedge clk) disable iff (!rst_n)
        (int_ack && !int_req && !bus_wr) |=> $stable(isr)); // R11
endmodule

// File: tb/pic8_core_test.sv
module pic8_core_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       bus_wr = 1'b0, bus_sel = 1'b0, int_ack = 1'b0;
    logic [7:0] bus_wdata = 8'h00, irq_in = 8'h00;
    logic [7:0] bus_rdata, int_vector, cascade_id;
    logic       int_req, init_done;

    int runs = 0, fails = 0;
    bit finished = 0;
    logic [7:0] exp_q[$];
    string      tag_q[$];

    always #4 clk = ~clk;

    pic8_core uut (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_sel(bus_sel),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq_in(irq_in),
        .int_req(int_req), .int_ack(int_ack), .int_vector(int_vector),
        .cascade_id(cascade_id), .init_done(init_done)
    );

    task automatic check(string req, logic [7:0] act, logic [7:0] exp);
        runs++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: got %02h expected %02h", req, act, exp);
        end
    endtask

    task automatic wr(logic sel, logic [7:0] d);
        @(posedge clk); #1;
        bus_wr = 1'b1; bus_sel = sel; bus_wdata = d;
        @(posedge clk); #1;
        bus_wr = 1'b0; bus_sel = 1'b1;
    endtask

    task automatic drive_irq(logic [7:0] v);
        @(posedge clk); #1;
        irq_in = v;
        @(posedge clk); #1;
    endtask

    task automatic ack(string req, logic [7:0] exp);
        exp_q.push_back(exp);
        tag_q.push_back(req);
        @(posedge clk); #1;
        int_ack = 1'b1;
        @(posedge clk); #1;
        int_ack = 1'b0;
    endtask

    always @(negedge clk) begin
        if (int_ack) begin
            if (exp_q.size() == 0) begin
                runs++; fails++;
                $display("FAIL R8: unexpected ack, got %02h expected none", int_vector);
            end else begin
                check(tag_q.pop_front(), int_vector, exp_q.pop_front());
            end
        end
    end

    initial begin
        #(8 * 200000);
        if (!finished) begin
            runs++; fails++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("  [TB] %0d tests run, %0d failed", runs, fails);
            $finish;
        end
    end

    initial begin
        bus_sel = 1'b1;
        #20 rst_n = 1'b1;
        @(posedge clk); #1;
        check("R1 done", {7'd0, init_done}, 8'h00);
        check("R1 int", {7'd0, int_req}, 8'h00);
        check("R1 mask", bus_rdata, 8'hFF);
        check("R1 cas", cascade_id, 8'h00);

        // R2 R3: configuration sequence
        wr(1'b0, 8'h11);
        check("R2 mask cleared", bus_rdata, 8'h00);
        wr(1'b1, 8'h08);
        wr(1'b1, 8'h04);
        check("R3 not yet done", {7'd0, init_done}, 8'h00);
        check("R3 cas", cascade_id, 8'h04);
        wr(1'b1, 8'h01);
        check("R3 done", {7'd0, init_done}, 8'h01);

        // R4 mask load and reads
        wr(1'b1, 8'hFF);
        check("R4 mask read", bus_rdata, 8'hFF);
        bus_sel = 1'b0; #1;
        check("R4 cmd read", bus_rdata, 8'h00);
        bus_sel = 1'b1;

        // R6 masked request retained
        drive_irq(8'h08);
        check("R6 masked", {7'd0, int_req}, 8'h00);
        wr(1'b1, 8'hF7);
        check("R6 unmasked", {7'd0, int_req}, 8'h01);
        ack("R8 vector line3", 8'h0B);
        check("R8 retired", {7'd0, int_req}, 8'h00);

        // R9 nesting
        wr(1'b1, 8'h00);
        drive_irq(8'h28);
        check("R9 lower blocked", {7'd0, int_req}, 8'h00);
        drive_irq(8'h2A);
        check("R9 higher passes", {7'd0, int_req}, 8'h01);
        ack("R9 vector line1", 8'h09);
        check("R9 after ack", {7'd0, int_req}, 8'h00);

        // R10 specific end of interrupt
        wr(1'b0, 8'h61);
        check("R10 isr3 still blocks", {7'd0, int_req}, 8'h00);
        wr(1'b0, 8'h63);
        check("R10 line5 released", {7'd0, int_req}, 8'h01);

        // R12 unknown command
        wr(1'b0, 8'h80);
        check("R12 int kept", {7'd0, int_req}, 8'h01);
        check("R12 mask kept", bus_rdata, 8'h00);
        check("R12 done kept", {7'd0, init_done}, 8'h01);
        ack("R8 vector line5", 8'h0D);
        wr(1'b0, 8'h65);

        // R11 spurious ack
        check("R11 idle", {7'd0, int_req}, 8'h00);
        ack("R11 spurious vector", 8'h0F);
        check("R11 still idle", {7'd0, int_req}, 8'h00);

        // R5 held levels do not re-request, new edge does
        drive_irq(8'h2A);
        check("R5 level ignored", {7'd0, int_req}, 8'h00);
        drive_irq(8'h28);
        drive_irq(8'h2A);
        check("R5 new edge", {7'd0, int_req}, 8'h01);
        ack("R5 vector line1", 8'h09);
        wr(1'b0, 8'h61);

        // R7 simultaneous requests
        drive_irq(8'h00);
        drive_irq(8'h44);
        ack("R7 line2 first", 8'h0A);
        check("R7 line6 blocked", {7'd0, int_req}, 8'h00);
        wr(1'b0, 8'h62);
        ack("R7 line6 next", 8'h0E);
        wr(1'b0, 8'h66);

        // R2 reconfiguration clears service
        drive_irq(8'h00);
        drive_irq(8'h10);
        ack("R8 vector line4", 8'h0C);
        drive_irq(8'h90);
        check("R9 line7 blocked", {7'd0, int_req}, 8'h00);
        wr(1'b0, 8'h11);
        check("R2 done dropped", {7'd0, init_done}, 8'h00);
        check("R3 quiet in init", {7'd0, int_req}, 8'h00);
        wr(1'b1, 8'h20);
        wr(1'b1, 8'h02);
        wr(1'b1, 8'h01);
        check("R3 cas secondary", cascade_id, 8'h02);
        check("R2 isr cleared", {7'd0, int_req}, 8'h01);
        ack("R2 vector line7", 8'h27);

        repeat (2) @(posedge clk);
        #1;
        check("R8 queue drained", 8'(exp_q.size()), 8'h00);
        finished = 1;
        $display("  [TB] %0d tests run, %0d failed", runs, fails);
        $finish;
    end
endmodule